// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion on its own free-running conversion clock. A start pulse opens a sampling phase. The phase lasts a fixed number of clocks, so the analog input has time to settle on the sampling capacitance. The block then enters hold. It waits a settling interval and resolves the code one bit at a time, most significant bit first. For each bit it drives a trial code to an external comparator and reads back a single compare bit.

When the last bit is resolved, the code is stored and marked valid, and a one-cycle completion pulse is raised. The stored code stays available for any length of time until the serial side reads it. The read discards it, and a fresh start then begins the next conversion.

An abort input stops any phase at once. It clears the trial code and discards the stored code.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy`, `sampling`, `doneStrobe` and `resultValid` are 0 and `trialCode` is 0.
- R2: A `startReq` seen while idle raises `busy` and holds `sampling` high for exactly `HOLD_CYC` clocks. `HOLD_CYC` is 1 us rounded up to whole clocks; with the defaults (2097 kHz) it is 3.
- R3: After sampling ends, `trialCode` stays 0 for `SETTLE_CYC` clocks (default 10). The first trial code is then the most significant bit alone (0x80 for 8 bits).
- R4: Each bit trial takes two clocks with its bit set in `trialCode`. The compare bit `cmpHigh` (1 means the input is at or above the trial level) is taken in the second clock. The bit is kept only when `cmpHigh` is 1, and the next lower bit is then set.
- R5: From the end of sampling to the fall of `busy`, a conversion takes `SETTLE_CYC + 2*RES_BITS` clocks, which is 26 with the defaults. The allowed window is 26 to 32.
- R6: On completion, `result` equals the largest code whose trial level the input reaches. `resultValid` rises and `doneStrobe` is high for exactly one clock, in the same clock that `busy` falls.
- R7: A valid result and its flag stay unchanged for as long as no read, abort or new completion occurs. A `readAck` pulse clears `resultValid`.
- R8: A `startReq` while `busy` is ignored. The running conversion keeps its timing and its result.
- R9: `abortReq` has priority over all other inputs. One clock later `busy`, `sampling`, `trialCode` and `resultValid` are 0. They stay so until a later conversion completes.
- R10: A comparator input at mid-scale, such as the internal test level with reference equal to supply, yields a code between 125 and 130.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, free running |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse from the serial side |
| abortReq | input | 1 | Abort pulse, highest priority |
| readAck | input | 1 | Result has been shifted out |
| cmpHigh | input | 1 | Comparator: input at or above the trial level |
| trialCode | output | RES_BITS | Code driven to the comparator ladder |
| sampling | output | 1 | Input switch in sample mode |
| busy | output | 1 | Conversion in progress |
| doneStrobe | output | 1 | One-clock completion pulse |
| result | output | RES_BITS | Stored conversion code |
| resultValid | output | 1 | Stored code not yet read or discarded |

## Verification
The in-line assertions check several properties on every clock:
- sampling never occurs outside `busy`;
- an abort empties the sequencer one clock later;
- a start during a conversion never reopens sampling;
- each trial moves the code up or down according to the compare bit;
- the hold-to-finish count is exact;
- the completion pulse lasts one clock and coincides with a valid result.

Other behaviours appear only in the bench scenarios, which drive a digital comparator model:
- the exact sampling and settling lengths;
- the final codes across a spread of input levels, including the extremes and mid-scale;
- indefinite retention of a result before it is read;
- recovery of the valid flag after an abort.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_SETTLE = 3'd2,
    PH_TRY    = 3'd3,
    PH_JUDGE  = 3'd4
  } phase_t;

  // strobes from sequencing control to the code datapath
  typedef struct packed {
    logic wipe;      // abort: clear trial and validity
    logic loadMsb;   // begin trials with the top bit
    logic judge;     // take compare bit for current trial
    logic lastBit;   // current trial is bit 0
    logic readClr;   // stored code consumed
  } seq_strobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int HOLD_CYC   = 3,
  parameter int SETTLE_CYC = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        startReq,
  input  logic                        abortReq,
  input  logic                        readAck,
  output seq_strobe_t                 stb,
  output logic [$clog2(RES_BITS)-1:0] bitIdx,
  output logic                        sampling,
  output logic                        busy,
  output logic                        doneStrobe
);

  localparam int IDX_W    = $clog2(RES_BITS);
  localparam int CNT_MAX  = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int CONV_CYC = SETTLE_CYC + 2 * RES_BITS;
  localparam int CHK_W    = $clog2(CONV_CYC + 2);

  phase_t            phase;
  logic [CNT_W-1:0]  waitCnt;
  logic [IDX_W-1:0]  curBit;

  always_comb begin
    stb.wipe    = abortReq;
    stb.loadMsb = !abortReq && (phase == PH_SETTLE) && (waitCnt == '0);
    stb.judge   = !abortReq && (phase == PH_JUDGE);
    stb.lastBit = (curBit == '0);
    stb.readClr = readAck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      waitCnt    <= '0;
      curBit     <= '0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= 1'b0;
      if (abortReq) begin
        phase   <= PH_IDLE;
        waitCnt <= '0;
        curBit  <= '0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            if (startReq) begin
              phase   <= PH_SAMPLE;
              waitCnt <= CNT_W'(HOLD_CYC - 1);
            end
          end
          PH_SAMPLE: begin
            if (waitCnt == '0) begin
              phase   <= PH_SETTLE;
              waitCnt <= CNT_W'(SETTLE_CYC - 1);
            end else begin
              waitCnt <= waitCnt - 1'b1;
            end
          end
          PH_SETTLE: begin
            if (waitCnt == '0) begin
              phase  <= PH_TRY;
              curBit <= IDX_W'(RES_BITS - 1);
            end else begin
              waitCnt <= waitCnt - 1'b1;
            end
          end
          PH_TRY: phase <= PH_JUDGE;
          PH_JUDGE: begin
            if (curBit == '0) begin
              phase      <= PH_IDLE;
              doneStrobe <= 1'b1;
            end else begin
              phase  <= PH_TRY;
              curBit <= curBit - 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign bitIdx   = curBit;
  assign sampling = (phase == PH_SAMPLE);
  assign busy     = (phase != PH_IDLE);

  // checker counter: clocks spent in hold since sampling ended
  logic [CHK_W-1:0] holdSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdSeen <= '0;
    else if (phase == PH_SETTLE || phase == PH_TRY || phase == PH_JUDGE)
      holdSeen <= holdSeen + 1'b1;
    else holdSeen <= '0;
  end

  assert_sample_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> busy);

  assert_abort_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abortReq |=> (!busy && !sampling));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sampling && startReq && !abortReq) |=> !sampling);

  assert_conv_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_JUDGE && curBit == '0 && !abortReq) |-> (holdSeen == CHK_W'(CONV_CYC - 1)));

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seq_strobe_t                 stb,
  input  logic [$clog2(RES_BITS)-1:0] bitIdx,
  input  logic                        cmpHigh,
  output logic [RES_BITS-1:0]         trialCode,
  output logic [RES_BITS-1:0]         result,
  output logic                        resultValid
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] trialReg;
  logic [RES_BITS-1:0] keptCode;
  logic [RES_BITS-1:0] nextBitMask;
  logic [RES_BITS-1:0] curMask;

  always_comb begin
    curMask     = '0;
    nextBitMask = '0;
    for (int i = 0; i < RES_BITS; i++) begin
      if (int'(bitIdx) == i) curMask[i] = 1'b1;
      if (int'(bitIdx) == i + 1) nextBitMask[i] = 1'b1;
    end
    keptCode = cmpHigh ? trialReg : (trialReg & ~curMask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trialReg    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else if (stb.wipe) begin
      trialReg    <= '0;
      resultValid <= 1'b0;
    end else begin
      if (stb.readClr) resultValid <= 1'b0;
      if (stb.loadMsb) begin
        trialReg <= TOP_BIT;
      end else if (stb.judge) begin
        if (stb.lastBit) begin
          result      <= keptCode;
          resultValid <= 1'b1;
          trialReg    <= '0;
        end else begin
          trialReg <= keptCode | nextBitMask;
        end
      end
    end
  end

  assign trialCode = trialReg;

  assert_trial_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.judge && !stb.wipe && !stb.lastBit && cmpHigh) |=> (trialCode > $past(trialCode)));

  assert_trial_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.judge && !stb.wipe && !stb.lastBit && !cmpHigh) |=> (trialCode < $past(trialCode)));

  assert_wipe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wipe |=> (trialCode == '0 && !resultValid));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int CLK_KHZ    = 2097,
  parameter int SAMPLE_NS  = 1000,
  parameter int SETTLE_CYC = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic                abortReq,
  input  logic                readAck,
  input  logic                cmpHigh,
  output logic [RES_BITS-1:0] trialCode,
  output logic                sampling,
  output logic                busy,
  output logic                doneStrobe,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid
);

  localparam int HOLD_RAW = (SAMPLE_NS * CLK_KHZ + 999999) / 1000000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int IDX_W    = $clog2(RES_BITS);

  seq_strobe_t      stb;
  logic [IDX_W-1:0] bitIdx;

  sar_ctrl #(
    .RES_BITS  (RES_BITS),
    .HOLD_CYC  (HOLD_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .abortReq  (abortReq),
    .readAck   (readAck),
    .stb       (stb),
    .bitIdx    (bitIdx),
    .sampling  (sampling),
    .busy      (busy),
    .doneStrobe(doneStrobe)
  );

  sar_datapath #(
    .RES_BITS(RES_BITS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .bitIdx     (bitIdx),
    .cmpHigh    (cmpHigh),
    .trialCode  (trialCode),
    .result     (result),
    .resultValid(resultValid)
  );

  assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneStrobe |-> (resultValid && !busy));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneStrobe |=> !doneStrobe);

  assert_hold_no_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> (trialCode == '0));

endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startReq = 1'b0, abortReq = 1'b0, readAck = 1'b0;
  logic [7:0] stimCode = 8'd0;
  logic       cmpHigh;
  logic [7:0] trialCode, result;
  logic       sampling, busy, doneStrobe, resultValid;

  int errCnt = 0;
  int chkCnt = 0;

  always #5 clk = ~clk;

  // comparator model: input at or above trial level
  assign cmpHigh = (stimCode >= trialCode);

  sar_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .abortReq(abortReq),
    .readAck(readAck), .cmpHigh(cmpHigh), .trialCode(trialCode),
    .sampling(sampling), .busy(busy), .doneStrobe(doneStrobe),
    .result(result), .resultValid(resultValid)
  );

  localparam int NVEC = 9;
  localparam logic [7:0] VEC_IN [NVEC] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h55,
                                           8'hAA, 8'h01, 8'hFE, 8'h3C};

  task automatic check(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // run one conversion; optionally pulse start again during hold
  task automatic runConv(input logic [7:0] lvl, input bit poke);
    int sampN, settleN, holdN;
    stimCode = lvl;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R2 busy after start", busy, 1);
    sampN = 0;
    while (sampling && sampN < 100) begin sampN++; @(negedge clk); end
    check("R2 sampling length", sampN, 3);
    settleN = 0; holdN = 0;
    while (busy && trialCode == 8'd0 && settleN < 100) begin
      if (poke && settleN == 2) startReq = 1'b1; else startReq = 1'b0;
      settleN++; holdN++; @(negedge clk);
    end
    startReq = 1'b0;
    check("R3 settle length", settleN, 10);
    check("R3 first trial", trialCode, 8'h80);
    while (busy && holdN < 200) begin holdN++; @(negedge clk); end
    check("R5 hold-to-done cycles", holdN, 26);
    check("R6 result code", result, lvl);
    check("R6 valid", resultValid, 1);
    check("R6 done pulse", doneStrobe, 1);
    check("R8 no restart", sampling, 0);
    @(negedge clk);
    check("R6 done one clock", doneStrobe, 0);
  endtask

  initial begin
    // reset
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 sampling", sampling, 0);
    check("R1 valid", resultValid, 0);
    check("R1 trial", trialCode, 0);
    check("R1 done", doneStrobe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) runConv(VEC_IN[v], 1'b0);

    // R4: watch one trial sequence for input 0x55
    begin
      int trace [16];
      stimCode = 8'h55;
      @(negedge clk); startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      repeat (13) @(negedge clk);
      for (int k = 0; k < 16; k++) begin trace[k] = trialCode; @(negedge clk); end
      check("R4 bit7 trial 2 clocks", trace[1], 8'h80);
      check("R4 bit7 dropped, bit6 set", trace[2], 8'h40);
      check("R4 bit6 kept, bit5 set", trace[4], 8'h60);
      check("R4 bit5 dropped, bit4 set", trace[6], 8'h50);
      check("R4 last trial", trace[14], 8'h55);
      check("R4 final", result, 8'h55);
    end

    // R8: start pulsed during hold is ignored
    runConv(8'hC3, 1'b1);

    // R7: retained indefinitely, then cleared by read
    repeat (60) @(negedge clk);
    check("R7 valid kept", resultValid, 1);
    check("R7 code kept", result, 8'hC3);
    readAck = 1'b1; @(negedge clk); readAck = 1'b0;
    check("R7 read clears valid", resultValid, 0);

    // R10: mid-scale test level
    runConv(8'h80, 1'b0);
    check("R10 mid-scale in range", (result >= 8'd125 && result <= 8'd130), 1);

    // R9: abort mid-trial
    stimCode = 8'h9A;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    repeat (18) @(negedge clk);
    check("R9 trial active before abort", (trialCode != 0), 1);
    abortReq = 1'b1; startReq = 1'b1; @(negedge clk); abortReq = 1'b0; startReq = 1'b0;
    check("R9 busy dropped", busy, 0);
    check("R9 trial cleared", trialCode, 0);
    check("R9 valid cleared", resultValid, 0);
    check("R9 sampling off", sampling, 0);
    repeat (40) @(negedge clk);
    check("R9 stays invalid", resultValid, 0);
    check("R9 stays idle", busy, 0);

    // R9: abort during sampling, then recovery
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check("R9 sampling before abort", sampling, 1);
    abortReq = 1'b1; @(negedge clk); abortReq = 1'b0;
    check("R9 abort in sampling", sampling | busy, 0);
    runConv(8'h9A, 1'b0);
    check("R9 recovery valid", resultValid, 1);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule